// File: doc/BRIEF.md
# SpaceWire Time-Code Counter Unit

This block holds the system time of a SpaceWire node. The time is a 6-bit counter plus two control flags. A tick-in strobe advances the counter by one. It then asks the link transmitter to send a time-code made of the advanced count and the present flags. A time-code received from the link replaces the stored time and raises a one-cycle tick-out pulse.

Software reaches the value through a 32-bit read/write port. A write loads the counter and flags without sending anything. Only a tick-in sends a time-code. The transmitter takes codes through a request/acknowledge pair. A request stays up until it is acknowledged. A newer tick-in replaces a code that has not been taken yet.

When several sources act in the same cycle, they are applied in a fixed order. A received code wins over a software write. The tick-in is applied last, so it advances whichever value was just loaded.

Top module: `spw_time_unit`

## Requirements
- R1: The read port returns the counter in bits 5:0 and the flags in bits 7:6. Bits 31:8 always read zero, and bits 31:8 of a write are ignored.
- R2: After a synchronous active-low reset, the read value is zero, `tx_req` is low, `tx_code` is zero and `tick_out` is low.
- R3: A tick-in adds one to the counter and wraps it from 63 to 0. The flags are left as they are.
- R4: One cycle after a tick-in, `tx_req` is high and `tx_code` equals the new stored value: bits 7:6 are the flags and bits 5:0 are the advanced count.
- R5: A software write with no tick-in stores write bits 7:0 on the next cycle. It raises no request and leaves `tx_req` and `tx_code` unchanged.
- R6: If a write and a tick-in fall in the same cycle, the stored value is the written value with its count advanced by one. That value is also the code sent.
- R7: When `rx_valid` is high, `rx_code` is stored on the next cycle, laid out as in R1. `tick_out` is high for exactly that one cycle.
- R8: `tx_req` stays high with `tx_code` unchanged until `tx_ack` is sampled high at a clock edge. It drops on the following cycle unless a tick-in came in the same cycle.
- R9: A tick-in while a request is pending keeps `tx_req` high and replaces `tx_code` with the newer value. An acknowledge in that same cycle applies to the old code.
- R10: A received code takes priority over a software write in the same cycle. A tick-in in the same cycle as a received code advances the received count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle strobe to advance the time and send a code |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wr_data | input | 32 | Software write data; bits 7:0 used |
| reg_rd_data | output | 32 | Current time value, zero-extended |
| rx_valid | input | 1 | Received time-code strobe |
| rx_code | input | 8 | Received time-code (flags 7:6, count 5:0) |
| tx_req | output | 1 | Time-code send request |
| tx_code | output | 8 | Time-code offered to the transmitter |
| tx_ack | input | 1 | Transmitter has taken the offered code |
| tick_out | output | 1 | One-cycle pulse after a received code is stored |

## Verification
The assertions assume that `tick_in` and `rx_valid` are single-cycle strobes. They assume `tx_ack` is only meaningful while `tx_req` is high. They also assume the reset is held for at least one edge before any check starts. The bench keeps within these assumptions. It drives every input at the falling edge for exactly one cycle per vector. It pulses `tx_ack` only while a request is pending, or in the same cycle as a tick-in to test the override. It starts every sequence from a full reset cycle.

// File: rtl/spw_time_pkg.sv
// Shared widths and the time word layout for the time-code counter unit.
// Assumes the flags sit above the count, as the link code needs.
package spw_time_pkg;
    localparam int TC_CNT_W  = 6;
    localparam int TC_FLAG_W = 2;
    localparam int TC_W      = TC_CNT_W + TC_FLAG_W;

    typedef struct packed {
        logic [TC_FLAG_W-1:0] flags;
        logic [TC_CNT_W-1:0]  count;
    } time_word_t;
endpackage

// File: rtl/spw_time_store.sv
// Holds the time word and applies updates in a fixed order:
// received code, then software write, then tick-in.
// Produces the next value combinationally so the send path can capture it.
// Assumes tick_in and rx_valid are single-cycle strobes.
module spw_time_store
    import spw_time_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_in,
    input  logic                  wr_en,
    input  logic [TC_W-1:0]       wr_word,
    input  logic                  rx_valid,
    input  logic [TC_W-1:0]       rx_word,
    output time_word_t            cur_word,
    output time_word_t            next_word,
    output logic                  tick_out
);
    time_word_t base_word;

    // Pick the load source before the increment; the link code wins over software.
    always_comb begin
        if (rx_valid)
            base_word = time_word_t'(rx_word);
        else if (wr_en)
            base_word = time_word_t'(wr_word);
        else
            base_word = cur_word;
        next_word = base_word;
        if (tick_in)
            next_word.count = base_word.count + 1'b1;
    end

    // Register the time word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_word <= '0;
        else
            cur_word <= next_word;
    end

    // Pulse tick-out for one cycle after a received code is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_out <= 1'b0;
        else
            tick_out <= rx_valid;
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !wr_en && !rx_valid) |=>
            (cur_word.count == TC_CNT_W'($past(cur_word.count) + 1'b1)) &&
            (cur_word.flags == $past(cur_word.flags)));

    assert_rx_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !tick_in) |=> (cur_word == $past(rx_word)) && tick_out);

    assert_rx_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && wr_en && !tick_in) |=> (cur_word == $past(rx_word)));

    assert_no_stray_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !tick_out);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !wr_en && !rx_valid) |=> $stable(cur_word));
endmodule

// File: rtl/spw_time_sender.sv
// Offers time-codes to the link transmitter with a request/acknowledge pair.
// A new load replaces any pending code; an ack drops the request otherwise.
// Assumes tx_ack is only meaningful while tx_req is high.
module spw_time_sender
    import spw_time_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TC_W-1:0] load_code,
    input  logic            tx_ack,
    output logic            tx_req,
    output logic [TC_W-1:0] tx_code
);
    // Hold the request until acknowledged; a fresh load takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_req  <= 1'b0;
            tx_code <= '0;
        end else if (load) begin
            tx_req  <= 1'b1;
            tx_code <= load_code;
        end else if (tx_req && tx_ack) begin
            tx_req  <= 1'b0;
        end
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack && !load) |=> tx_req && $stable(tx_code));

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ack && !load) |=> !tx_req);

    assert_replace_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tx_req && (tx_code == $past(load_code)));
endmodule

// File: rtl/spw_time_unit.sv
// Top of the time-code counter unit: register port, time store and code sender.
// Software writes load the time silently; tick-in advances and sends it.
// Assumes a synchronous active-low reset held for at least one edge.
module spw_time_unit
    import spw_time_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             rx_valid,
    input  logic [TC_W-1:0]  rx_code,
    output logic             tx_req,
    output logic [TC_W-1:0]  tx_code,
    input  logic             tx_ack,
    output logic             tick_out
);
    localparam int PAD_W = REG_W - TC_W;

    time_word_t cur_word;
    time_word_t next_word;

    spw_time_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .wr_en     (reg_wr_en),
        .wr_word   (reg_wr_data[TC_W-1:0]),
        .rx_valid  (rx_valid),
        .rx_word   (rx_code),
        .cur_word  (cur_word),
        .next_word (next_word),
        .tick_out  (tick_out)
    );

    spw_time_sender u_sender (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tick_in),
        .load_code (next_word),
        .tx_ack    (tx_ack),
        .tx_req    (tx_req),
        .tx_code   (tx_code)
    );

    // Zero-extend the time word onto the read port.
    always_comb reg_rd_data = {{PAD_W{1'b0}}, cur_word};

    assert_send_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_in |=> tx_req && (tx_code == reg_rd_data[TC_W-1:0]));

    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !tick_in && !tx_ack) |=> $stable(tx_req) && $stable(tx_code));

    assert_write_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && tick_in && !rx_valid) |=>
            (reg_rd_data[TC_W-1:TC_CNT_W] == $past(reg_wr_data[TC_W-1:TC_CNT_W])));
endmodule

// File: tb/tb_spw_time_unit.sv
module tb_spw_time_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_in, reg_wr_en, rx_valid, tx_ack;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic [7:0]  rx_code, tx_code;
    logic        tx_req, tick_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spw_time_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .rx_valid(rx_valid),
        .rx_code(rx_code), .tx_req(tx_req), .tx_code(tx_code), .tx_ack(tx_ack),
        .tick_out(tick_out)
    );

    typedef struct packed {
        logic       tick;
        logic       wr;
        logic [7:0] wd;
        logic       rx;
        logic [7:0] rc;
        logic       ack;
        logic [3:0] tag;
        logic [7:0] ev;
        logic       er;
        logic [7:0] et;
        logic       eto;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,4'd4, 8'h01,1'b1,8'h01,1'b0}, // R4 first tick sends 1
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,4'd8, 8'h01,1'b0,8'h01,1'b0}, // R8 ack drops request
        '{1'b0,1'b1,8'hC5,1'b0,8'h00,1'b0,4'd5, 8'hC5,1'b0,8'h01,1'b0}, // R5 silent write, R1 upper ignored
        '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,4'd4, 8'hC6,1'b1,8'hC6,1'b0}, // R4 flags carried
        '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,4'd9, 8'hC7,1'b1,8'hC7,1'b0}, // R9 replace pending
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,4'd8, 8'hC7,1'b1,8'hC7,1'b0}, // R8 held
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,4'd8, 8'hC7,1'b0,8'hC7,1'b0}, // R8 ack
        '{1'b0,1'b1,8'h3F,1'b0,8'h00,1'b0,4'd5, 8'h3F,1'b0,8'hC7,1'b0}, // R5 write 63
        '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,4'd3, 8'h00,1'b1,8'h00,1'b0}, // R3 wrap to 0
        '{1'b1,1'b0,8'h00,1'b0,8'h00,1'b1,4'd9, 8'h01,1'b1,8'h01,1'b0}, // R9 tick beats ack
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,4'd8, 8'h01,1'b0,8'h01,1'b0}, // R8 ack
        '{1'b0,1'b0,8'h00,1'b1,8'h9A,1'b0,4'd7, 8'h9A,1'b0,8'h01,1'b1}, // R7 receive
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,4'd7, 8'h9A,1'b0,8'h01,1'b0}, // R7 pulse ends
        '{1'b1,1'b1,8'h40,1'b0,8'h00,1'b0,4'd6, 8'h41,1'b1,8'h41,1'b0}, // R6 write plus tick
        '{1'b0,1'b1,8'h22,1'b1,8'h10,1'b1,4'd10,8'h10,1'b0,8'h41,1'b1}, // R10 rx over write
        '{1'b1,1'b0,8'h00,1'b1,8'h7F,1'b0,4'd10,8'h40,1'b1,8'h40,1'b1}, // R10 tick on rx value
        '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,4'd8, 8'h40,1'b0,8'h40,1'b0}  // R8 ack
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick_in = 0; reg_wr_en = 0; reg_wr_data = '0; rx_valid = 0; rx_code = '0; tx_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle_inputs();
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic check_reset_state();
        chk("R2", "rd", reg_rd_data, 32'h0);
        chk("R2", "req", {31'b0, tx_req}, 32'h0);
        chk("R2", "code", {24'b0, tx_code}, 32'h0);
        chk("R2", "tick_out", {31'b0, tick_out}, 32'h0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; idle_inputs();
        do_reset();
        check_reset_state(); // R2

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].tag);
            tick_in = VECS[i].tick; reg_wr_en = VECS[i].wr;
            reg_wr_data = {24'hFFFFFF, VECS[i].wd};
            rx_valid = VECS[i].rx; rx_code = VECS[i].rc; tx_ack = VECS[i].ack;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            chk(tag, "rd (R1 layout)", reg_rd_data, {24'h0, VECS[i].ev});
            chk(tag, "tx_req", {31'b0, tx_req}, {31'b0, VECS[i].er});
            chk(tag, "tx_code", {24'b0, tx_code}, {24'b0, VECS[i].et});
            chk(tag, "tick_out", {31'b0, tick_out}, {31'b0, VECS[i].eto});
        end

        // R8: request held over several cycles without ack
        tick_in = 1;
        @(posedge clk); @(negedge clk);
        tick_in = 0;
        for (int k = 0; k < 5; k++) begin
            chk("R8", "held req", {31'b0, tx_req}, 32'h1);
            chk("R8", "held code", {24'b0, tx_code}, 32'h41);
            @(posedge clk); @(negedge clk);
        end

        // R5: write while pending leaves request and code alone
        reg_wr_en = 1; reg_wr_data = 32'h0000_0080;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R5", "rd", reg_rd_data, 32'h80);
        chk("R5", "req kept", {31'b0, tx_req}, 32'h1);
        chk("R5", "code kept", {24'b0, tx_code}, 32'h41);

        // R2: reset in the middle of activity
        do_reset();
        check_reset_state();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule